// File: doc/BRIEF.md
# Branch Resolver with Count-Register Loops

This block settles branch instructions beside the main pipeline. It keeps three registers of its own, apart from the general-purpose file: a link register, a count register and a condition register of single-bit flags. A decoder hands it one branch at a time with the current fetch address, a word displacement and a handful of control bits. A private adder forms the target, and the block reports in the same cycle whether the branch goes and where fetch must continue. Branches that need no condition bit, or only the count register, cost no execution cycle.

Loop-closing branches decrement the count register and test the decremented value in one operation, so a counted loop needs a single instruction. If a branch waits on a condition bit that another unit has marked as not yet produced, the block follows the compiler's static hint bit and parks the branch. When that bit is written, the block compares the real outcome with the guess. After a wrong guess it raises a one-cycle flush with the correct resume address, and fetch restarts from the instructions it kept for the other path.

The controller has two states. `ST_IDLE` accepts branches. `ST_WAIT` holds one predicted branch. Transition `T_PARK` (ST_IDLE to ST_WAIT) happens when an accepted branch depends on a pending bit. Transition `T_SETTLE` (ST_WAIT to ST_IDLE) happens when that bit is written. Every other cycle stays in its state.

Top module: `branch_resolver`

## Requirements
- R1: After reset the link, count and condition registers are all zero, no condition bit is pending, `br_ready` is 1 and `flush` is 0.
- R2: With `br_to_ctr`=0 the target is the sign-extended `br_disp` shifted left by two bits. This value is added to `br_pc` when `br_abs`=0 and used alone when `br_abs`=1.
- R3: With `br_to_ctr`=1 the target is the count register with its two low bits forced to zero.
- R4: With `br_dec`=1 the count register is reduced by one at the clock edge of acceptance. The branch may be taken only if the reduced value is non-zero.
- R5: A branch with `br_use_cond`=0 resolves in its own cycle: `res_valid`=1 and `res_predicted`=0 while `br_valid` is high, with no added latency.
- R6: With `br_use_cond`=1 and the selected bit not pending, the branch is taken when condition bit `br_cond_idx` equals `br_cond_want` and the count test of R4 passes.
- R7: With `br_link`=1 the link register holds `br_pc`+4 after the accepting edge. With `br_link`=0 it keeps its value.
- R8: With `br_use_cond`=1 and the selected bit pending (set by `cr_hold_en`, cleared by a write), the outcome follows `br_hint` and `res_predicted`=1. `br_ready` then stays 0 until that bit index is written. Writes to other indices do not end the wait.
- R9: In the cycle after the awaited bit is written, `flush` is 1 for exactly one cycle if the real outcome differs from the guess. `flush_pc` is then the target when the branch should have gone, or `br_pc`+4 when it should not. A correct guess gives no flush.
- R10: A branch that is not taken reports `res_target` = `br_pc`+4. A taken one reports its target.
- R11: When `ctr_ld_en` and a decrementing branch meet in one cycle, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| br_valid | input | 1 | A decoded branch is presented |
| br_ready | output | 1 | Block can accept a branch (ST_IDLE) |
| br_to_ctr | input | 1 | Target from count register |
| br_abs | input | 1 | Displacement is absolute |
| br_link | input | 1 | Load link register with next address |
| br_dec | input | 1 | Decrement count register and test non-zero |
| br_use_cond | input | 1 | Branch depends on a condition bit |
| br_cond_idx | input | 5 | Selected condition bit |
| br_cond_want | input | 1 | Required value of that bit |
| br_hint | input | 1 | Static guess: 1 = taken |
| br_pc | input | 32 | Address of the branch |
| br_disp | input | 24 | Signed word displacement |
| cr_hold_en | input | 1 | Mark a condition bit pending |
| cr_hold_idx | input | 5 | Bit to mark pending |
| cr_wr_en | input | 1 | Write a condition bit |
| cr_wr_idx | input | 5 | Bit to write |
| cr_wr_val | input | 1 | Value written |
| ctr_ld_en | input | 1 | Load count register |
| ctr_ld_data | input | 32 | Count load value |
| res_valid | output | 1 | Branch resolved or predicted this cycle |
| res_taken | output | 1 | Branch goes (real or guessed) |
| res_predicted | output | 1 | Outcome is a guess |
| res_target | output | 32 | Next fetch address |
| flush | output | 1 | Wrong guess, restart fetch |
| flush_pc | output | 32 | Resume address for the flush |
| lr_q | output | 32 | Link register |
| ctr_q | output | 32 | Count register |
| cr_q | output | 32 | Condition register |

## Verification
The resolution outputs (`res_*`) depend only on the inputs and the registers, so they are due in the cycle the branch is presented. The bench drives at the falling edge and reads them 1 ns later, before the next rising edge. Link, count and condition updates, the drop of `br_ready` and `flush` are due one rising edge later. The bench reads them at the next falling edge. It also reads `flush` one more falling edge later to confirm that the pulse lasts only one cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } bru_state_t;
endpackage

// File: rtl/bru_target.sv
module bru_target #(
    parameter int AW = 32,
    parameter int DW = 24
) (
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] disp,
    input  logic          abs_sel,
    input  logic          to_ctr,
    input  logic [AW-3:0] ctr_hi,
    output logic [AW-1:0] tgt,
    output logic [AW-1:0] seq
);
    localparam int EXT = AW - DW - 2;

    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT{disp[DW-1]}}, disp, 2'b00};
        seq      = pc + AW'(4);
        if (to_ctr)
            tgt = {ctr_hi, 2'b00};
        else if (abs_sel)
            tgt = disp_ext;
        else
            tgt = pc + disp_ext;
    end
endmodule

// File: rtl/bru_spr.sv
module bru_spr #(
    parameter int AW  = 32,
    parameter int CRN = 32,
    localparam int IW = $clog2(CRN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_en,
    input  logic [AW-1:0] link_val,
    input  logic          ctr_ld_en,
    input  logic [AW-1:0] ctr_ld_data,
    input  logic          ctr_dec_en,
    input  logic          cr_wr_en,
    input  logic [IW-1:0] cr_wr_idx,
    input  logic          cr_wr_val,
    input  logic          cr_hold_en,
    input  logic [IW-1:0] cr_hold_idx,
    output logic [AW-1:0] lr,
    output logic [AW-1:0] ctr,
    output logic [CRN-1:0] cr,
    output logic [CRN-1:0] cr_pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr  <= '0;
            ctr <= '0;
        end else begin
            if (link_en)
                lr <= link_val;
            if (ctr_ld_en)
                ctr <= ctr_ld_data;
            else if (ctr_dec_en)
                ctr <= ctr - AW'(1);
        end
    end

    for (genvar i = 0; i < CRN; i++) begin : g_crbit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cr[i]      <= 1'b0;
                cr_pend[i] <= 1'b0;
            end else begin
                if (cr_wr_en && cr_wr_idx == IW'(i))
                    cr[i] <= cr_wr_val;
                if (cr_hold_en && cr_hold_idx == IW'(i))
                    cr_pend[i] <= 1'b1;
                else if (cr_wr_en && cr_wr_idx == IW'(i))
                    cr_pend[i] <= 1'b0;
            end
        end
    end

    AST_CTR_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_ld_en |=> ctr == $past(ctr_ld_data)); // R11
    AST_WRITE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr_en && !(cr_hold_en && cr_hold_idx == cr_wr_idx)) |=> !cr_pend[$past(cr_wr_idx)]); // R8
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import bru_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 24,
    parameter int CRN = 32,
    localparam int IW = $clog2(CRN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           br_valid,
    output logic           br_ready,
    input  logic           br_to_ctr,
    input  logic           br_abs,
    input  logic           br_link,
    input  logic           br_dec,
    input  logic           br_use_cond,
    input  logic [IW-1:0]  br_cond_idx,
    input  logic           br_cond_want,
    input  logic           br_hint,
    input  logic [AW-1:0]  br_pc,
    input  logic [DW-1:0]  br_disp,
    input  logic           cr_hold_en,
    input  logic [IW-1:0]  cr_hold_idx,
    input  logic           cr_wr_en,
    input  logic [IW-1:0]  cr_wr_idx,
    input  logic           cr_wr_val,
    input  logic           ctr_ld_en,
    input  logic [AW-1:0]  ctr_ld_data,
    output logic           res_valid,
    output logic           res_taken,
    output logic           res_predicted,
    output logic [AW-1:0]  res_target,
    output logic           flush,
    output logic [AW-1:0]  flush_pc,
    output logic [AW-1:0]  lr_q,
    output logic [AW-1:0]  ctr_q,
    output logic [CRN-1:0] cr_q
);
    bru_state_t state, state_nx;

    logic [CRN-1:0] cr_pend;
    logic [AW-1:0]  tgt, seq;
    logic           accept, known, ctr_ok, taken, park;

    logic [IW-1:0]  w_idx;
    logic           w_want, w_ctr_ok, w_guess;
    logic [AW-1:0]  w_tgt, w_seq;
    logic           settle, actual;

    bru_target #(.AW(AW), .DW(DW)) u_tgt (
        .pc      (br_pc),
        .disp    (br_disp),
        .abs_sel (br_abs),
        .to_ctr  (br_to_ctr),
        .ctr_hi  (ctr_q[AW-1:2]),
        .tgt     (tgt),
        .seq     (seq)
    );

    bru_spr #(.AW(AW), .CRN(CRN)) u_spr (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_en     (accept && br_link),
        .link_val    (seq),
        .ctr_ld_en   (ctr_ld_en),
        .ctr_ld_data (ctr_ld_data),
        .ctr_dec_en  (accept && br_dec),
        .cr_wr_en    (cr_wr_en),
        .cr_wr_idx   (cr_wr_idx),
        .cr_wr_val   (cr_wr_val),
        .cr_hold_en  (cr_hold_en),
        .cr_hold_idx (cr_hold_idx),
        .lr          (lr_q),
        .ctr         (ctr_q),
        .cr          (cr_q),
        .cr_pend     (cr_pend)
    );

    // Decision logic for the presented branch
    always_comb begin
        accept = br_valid && (state == ST_IDLE);
        known  = !br_use_cond || !cr_pend[br_cond_idx];
        ctr_ok = !br_dec || ((ctr_q - AW'(1)) != '0);
        if (!br_use_cond)
            taken = ctr_ok;
        else if (known)
            taken = ctr_ok && (cr_q[br_cond_idx] == br_cond_want);
        else
            taken = ctr_ok && br_hint;
        park   = accept && !known;
        settle = (state == ST_WAIT) && cr_wr_en && (cr_wr_idx == w_idx);
        actual = w_ctr_ok && (cr_wr_val == w_want);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Next state and outputs
    always_comb begin
        state_nx      = state;
        br_ready      = 1'b0;
        res_valid     = 1'b0;
        res_taken     = 1'b0;
        res_predicted = 1'b0;
        res_target    = seq;
        unique case (state)
            ST_IDLE: begin
                br_ready      = 1'b1;
                res_valid     = accept;
                res_taken     = accept && taken;
                res_predicted = park;
                res_target    = taken ? tgt : seq;
                if (park)
                    state_nx = ST_WAIT;       // T_PARK
            end
            ST_WAIT: begin
                if (settle)
                    state_nx = ST_IDLE;       // T_SETTLE
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Parked branch record and recovery
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_idx    <= '0;
            w_want   <= 1'b0;
            w_ctr_ok <= 1'b0;
            w_guess  <= 1'b0;
            w_tgt    <= '0;
            w_seq    <= '0;
            flush    <= 1'b0;
            flush_pc <= '0;
        end else begin
            if (park) begin
                w_idx    <= br_cond_idx;
                w_want   <= br_cond_want;
                w_ctr_ok <= ctr_ok;
                w_guess  <= taken;
                w_tgt    <= tgt;
                w_seq    <= seq;
            end
            flush <= settle && (actual != w_guess);
            if (settle)
                flush_pc <= actual ? w_tgt : w_seq;
        end
    end

    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush); // R9
    AST_FLUSH_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(state == ST_WAIT)); // R9
    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !br_ready |-> !res_valid); // R8
    AST_NOCOND_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_ready && !br_use_cond) |-> (res_valid && !res_predicted)); // R5
    AST_LOOP_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && br_dec && !br_use_cond) |-> (res_taken == (ctr_q != AW'(1)))); // R4
    AST_LINK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && br_link) |=> lr_q == $past(br_pc) + AW'(4)); // R7
    AST_CTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_taken && br_to_ctr) |-> res_target[1:0] == 2'b00); // R3
endmodule

// File: tb/sim_branch_resolver.sv
module sim_branch_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 0, br_to_ctr = 0, br_abs = 0, br_link = 0, br_dec = 0;
    logic        br_use_cond = 0, br_cond_want = 0, br_hint = 0;
    logic [4:0]  br_cond_idx = 0;
    logic [31:0] br_pc = 0;
    logic [23:0] br_disp = 0;
    logic        cr_hold_en = 0, cr_wr_en = 0, cr_wr_val = 0, ctr_ld_en = 0;
    logic [4:0]  cr_hold_idx = 0, cr_wr_idx = 0;
    logic [31:0] ctr_ld_data = 0;
    logic        br_ready, res_valid, res_taken, res_predicted, flush;
    logic [31:0] res_target, flush_pc, lr_q, ctr_q, cr_q;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    branch_resolver u0 (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_ready(br_ready),
        .br_to_ctr(br_to_ctr), .br_abs(br_abs), .br_link(br_link), .br_dec(br_dec),
        .br_use_cond(br_use_cond), .br_cond_idx(br_cond_idx), .br_cond_want(br_cond_want),
        .br_hint(br_hint), .br_pc(br_pc), .br_disp(br_disp),
        .cr_hold_en(cr_hold_en), .cr_hold_idx(cr_hold_idx),
        .cr_wr_en(cr_wr_en), .cr_wr_idx(cr_wr_idx), .cr_wr_val(cr_wr_val),
        .ctr_ld_en(ctr_ld_en), .ctr_ld_data(ctr_ld_data),
        .res_valid(res_valid), .res_taken(res_taken), .res_predicted(res_predicted),
        .res_target(res_target), .flush(flush), .flush_pc(flush_pc),
        .lr_q(lr_q), .ctr_q(ctr_q), .cr_q(cr_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs;
        br_valid = 0; br_to_ctr = 0; br_abs = 0; br_link = 0; br_dec = 0;
        br_use_cond = 0; br_cond_want = 0; br_hint = 0; br_cond_idx = 0;
        cr_hold_en = 0; cr_wr_en = 0; ctr_ld_en = 0;
    endtask

    // present a branch at a falling edge; outputs read 1 ns later
    task automatic present(input logic [31:0] pc, input logic [23:0] d, input logic abs_b,
                           input logic to_c, input logic dec, input logic lnk);
        @(negedge clk);
        idle_inputs();
        br_valid = 1; br_pc = pc; br_disp = d; br_abs = abs_b;
        br_to_ctr = to_c; br_dec = dec; br_link = lnk;
        #1;
    endtask

    task automatic finish_cycle;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset;
        chk("R1 lr", lr_q, 0);
        chk("R1 ctr", ctr_q, 0);
        chk("R1 cr", cr_q, 0);
        chk("R1 ready", {31'd0, br_ready}, 1);
        chk("R1 flush", {31'd0, flush}, 0);
    endtask

    task automatic t_disp;
        present(32'h1000, 24'h000010, 0, 0, 0, 0);
        chk("R5 valid", {31'd0, res_valid}, 1);
        chk("R5 not predicted", {31'd0, res_predicted}, 0);
        chk("R2 relative fwd", res_target, 32'h0000_1040);
        present(32'h1000, 24'hFFFFFF, 0, 0, 0, 0);
        chk("R2 relative back", res_target, 32'h0000_0FFC);
        present(32'h1000, 24'h000100, 1, 0, 0, 0);
        chk("R2 absolute", res_target, 32'h0000_0400);
        present(32'h1000, 24'h800000, 1, 0, 0, 0);
        chk("R2 absolute signed", res_target, 32'hFE00_0000);
        finish_cycle();
    endtask

    task automatic t_link;
        present(32'h2000, 24'h4, 0, 0, 0, 1);
        finish_cycle();
        chk("R7 link loaded", lr_q, 32'h2004);
        present(32'h3000, 24'h4, 0, 0, 0, 0);
        finish_cycle();
        chk("R7 link kept", lr_q, 32'h2004);
    endtask

    task automatic t_ctr_target;
        @(negedge clk);
        idle_inputs();
        ctr_ld_en = 1; ctr_ld_data = 32'h1237;
        finish_cycle();
        chk("R11 ctr loaded", ctr_q, 32'h1237);
        present(32'h5000, 24'h0, 0, 1, 0, 0);
        chk("R3 taken", {31'd0, res_taken}, 1);
        chk("R3 ctr target", res_target, 32'h1234);
        finish_cycle();
    endtask

    task automatic t_loop;
        @(negedge clk);
        idle_inputs();
        ctr_ld_en = 1; ctr_ld_data = 2;
        present(32'h6000, 24'hFFFFFE, 0, 0, 1, 0);
        chk("R4 count 2 taken", {31'd0, res_taken}, 1);
        chk("R4 loop target", res_target, 32'h5FF8);
        finish_cycle();
        chk("R4 ctr after dec", ctr_q, 1);
        present(32'h6000, 24'hFFFFFE, 0, 0, 1, 0);
        chk("R4 count 1 falls through", {31'd0, res_taken}, 0);
        chk("R10 seq target", res_target, 32'h6004);
        finish_cycle();
        chk("R4 ctr zero", ctr_q, 0);
        present(32'h6000, 24'hFFFFFE, 0, 0, 1, 0);
        ctr_ld_en = 1; ctr_ld_data = 5;
        finish_cycle();
        chk("R11 load beats dec", ctr_q, 5);
    endtask

    task automatic t_cond_known;
        @(negedge clk);
        idle_inputs();
        cr_wr_en = 1; cr_wr_idx = 3; cr_wr_val = 1;
        finish_cycle();
        chk("R6 cr bit written", cr_q, 32'h8);
        present(32'h7000, 24'h20, 0, 0, 0, 0);
        br_use_cond = 1; br_cond_idx = 3; br_cond_want = 1; #1;
        chk("R6 match taken", {31'd0, res_taken}, 1);
        chk("R6 resolved", {31'd0, res_predicted}, 0);
        br_cond_want = 0; #1;
        chk("R6 mismatch not taken", {31'd0, res_taken}, 0);
        chk("R10 seq on cond", res_target, 32'h7004);
        finish_cycle();
    endtask

    task automatic t_predict(input logic [4:0] idx, input logic hint,
                             input logic wval, input logic exp_flush,
                             input logic [31:0] exp_pc);
        @(negedge clk);
        idle_inputs();
        cr_hold_en = 1; cr_hold_idx = idx;
        present(32'h8000, 24'h40, 0, 0, 0, 0);
        br_use_cond = 1; br_cond_idx = idx; br_cond_want = 1; br_hint = hint; #1;
        chk("R8 predicted", {31'd0, res_predicted}, 1);
        chk("R8 follows hint", {31'd0, res_taken}, {31'd0, hint});
        chk("R8 guessed target", res_target, hint ? 32'h8100 : 32'h8004);
        finish_cycle();
        chk("R8 not ready", {31'd0, br_ready}, 0);
        cr_wr_en = 1; cr_wr_idx = idx + 5'd1; cr_wr_val = 1;
        finish_cycle();
        chk("R8 other bit keeps wait", {31'd0, br_ready}, 0);
        chk("R9 no flush on other bit", {31'd0, flush}, 0);
        cr_wr_en = 1; cr_wr_idx = idx; cr_wr_val = wval;
        finish_cycle();
        chk("R9 flush", {31'd0, flush}, {31'd0, exp_flush});
        if (exp_flush) chk("R9 resume pc", flush_pc, exp_pc);
        chk("R8 ready again", {31'd0, br_ready}, 1);
        finish_cycle();
        chk("R9 one-cycle pulse", {31'd0, flush}, 0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_disp();
        t_link();
        t_ctr_target();
        t_loop();
        t_cond_known();
        t_predict(5'd7, 1'b1, 1'b0, 1'b1, 32'h8004);
        t_predict(5'd9, 1'b0, 1'b1, 1'b1, 32'h8100);
        t_predict(5'd12, 1'b1, 1'b1, 1'b0, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule